// File: doc/BRIEF.md
# Up/Down Event Counter with Quadrature Decode

A 16-bit counter whose count source is chosen by a two-bit mode field. In pin mode it steps once for every rising and every falling edge seen on an external clock pin. The level of an external direction pin sets the direction of each step. In quadrature mode the same two pins carry the A and B phases of an incremental encoder. The counter then steps on each of the four transitions in an encoder cycle, and the phase order gives the direction. Two more modes take their steps from an internal power-of-two prescaler or from a one-cycle tick produced by another timer. In both of these, the direction pin still sets the sense.

Both pins pass through a two-flop synchroniser before any edge is detected. A pin change therefore shows on the count output three clock cycles after the change is sampled. Software can load any value through a load strobe and value bus. A clear strobe from neighbouring logic forces the count to zero. The count wraps modulo 2^16 in both directions.

Top module: `timer_quad`

## Requirements
- R1: After rst_ni is released, count_o is 0.
- R2: In pin mode (mode_i = 1), each rising and each falling edge of tclk_pin_i changes count_o by one, no later than three clock cycles after the edge. A change on tdir_pin_i alone does not step the count.
- R3: In pin, prescaler and cascade modes, a step increments when tdir_pin_i is 1 and decrements when it is 0.
- R4: In quadrature mode (mode_i = 3), with A = tclk_pin_i and B = tdir_pin_i, the pair {A,B} stepping 00→10→11→01→00 adds one per transition. The reverse order subtracts one per transition.
- R5: In quadrature mode, a transition in which A and B both change together leaves count_o unchanged.
- R6: In prescaler mode (mode_i = 0), the counter takes exactly one step per 2^presc_sel_i clock cycles.
- R7: In cascade mode (mode_i = 2), the counter takes one step for every clock cycle in which casc_tick_i is 1, and edges on tclk_pin_i have no effect.
- R8: The count wraps modulo 2^16: 0xFFFF plus one gives 0, and 0 minus one gives 0xFFFF.
- R9: When load_i is 1, count_o takes load_val_i on the next clock. This overrides any step in the same cycle.
- R10: When clr_i is 1, count_o becomes 0 on the next clock. This overrides both load and counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Source: 0 prescaler, 1 pin edges, 2 cascade, 3 quadrature |
| presc_sel_i | input | 3 | Prescaler divide is 2^presc_sel_i |
| tclk_pin_i | input | 1 | External clock pin, or phase A in quadrature mode |
| tdir_pin_i | input | 1 | External direction pin, or phase B in quadrature mode |
| casc_tick_i | input | 1 | One-cycle step request from another timer |
| load_i | input | 1 | Software load strobe |
| load_val_i | input | 16 | Value to load |
| clr_i | input | 1 | Clear strobe from other logic |
| count_o | output | 16 | Current count |

## Verification
On every cycle, the assertions check that clear and load win and land on the next clock. They also check that each step event from the source decoder moves the count by exactly one, wrapping, in the direction reported, and that the count holds when no event occurs. Only the bench scenarios can show that the decoder produces the right events. This covers counting on both clock-pin edges, quadrature direction and rejection of double transitions, the prescaler period, and the cascade mode ignoring the clock pin.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    SRC_PRESC = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_CASC  = 2'd2,
    SRC_QUAD  = 2'd3
  } src_e;
endpackage

// File: rtl/tq_sync.sv
module tq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tq_presc.sv
module tq_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + DIV_W'(1);
  end

  // low sel_i bits all ones -> one tick per 2^sel_i cycles
  assign mask   = (DIV_W'(1) << sel_i) - DIV_W'(1);
  assign tick_o = ((cnt_q & mask) == mask);
endmodule

// File: rtl/tq_event.sv
module tq_event
  import tq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       presc_tick_i,
  input  logic       casc_tick_i,
  output logic       ev_valid_o,
  output logic       ev_up_o
);
  logic a_q, b_q;
  logic a_chg, b_chg;
  src_e src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_chg = a_i ^ a_q;
  assign b_chg = b_i ^ b_q;
  assign src   = src_e'(mode_i);

  always_comb begin
    ev_valid_o = 1'b0;
    ev_up_o    = b_i;
    unique case (src)
      SRC_PRESC: ev_valid_o = presc_tick_i;
      SRC_PIN:   ev_valid_o = a_chg;
      SRC_CASC:  ev_valid_o = casc_tick_i;
      SRC_QUAD: begin
        // single-phase change only; A leading B counts up
        ev_valid_o = a_chg ^ b_chg;
        ev_up_o    = a_i ^ b_q;
      end
      default:   ev_valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tq_count.sv
module tq_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         ev_valid_i,
  input  logic         ev_up_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)           cnt_d = '0;
    else if (load_i)     cnt_d = load_val_i;
    else if (ev_valid_i) cnt_d = ev_up_i ? cnt_q + W'(1) : cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/timer_quad.sv
module timer_quad #(
  parameter int W      = 16,
  parameter int SEL_W  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             tclk_pin_i,
  input  logic             tdir_pin_i,
  input  logic             casc_tick_i,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic             clr_i,
  output logic [W-1:0]     count_o
);
  logic [1:0] pin_s;
  logic       presc_tick;
  logic       ev_valid, ev_up;

  tq_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tdir_pin_i, tclk_pin_i}),
    .q_o   (pin_s)
  );

  tq_presc #(.SEL_W(SEL_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (presc_sel_i),
    .tick_o(presc_tick)
  );

  tq_event u_event (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .a_i         (pin_s[0]),
    .b_i         (pin_s[1]),
    .presc_tick_i(presc_tick),
    .casc_tick_i (casc_tick_i),
    .ev_valid_o  (ev_valid),
    .ev_up_o     (ev_up)
  );

  tq_count #(.W(W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .ev_valid_i(ev_valid),
    .ev_up_i   (ev_up),
    .count_o   (count_o)
  );
endmodule

// File: rtl/timer_quad_chk.sv
module timer_quad_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         load_i,
  input logic [W-1:0] load_val_i,
  input logic         ev_valid,
  input logic         ev_up,
  input logic [W-1:0] count_o
);
  p_reset_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> count_o == '0);

  p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);

  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> count_o == $past(load_val_i));

  // R3 / R8: single step up, wrapping
  p_step_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && ev_valid && ev_up) |=> count_o == $past(count_o) + W'(1));

  p_step_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && ev_valid && !ev_up) |=> count_o == $past(count_o) - W'(1));

  p_hold_no_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !ev_valid) |=> $stable(count_o));
endmodule

bind timer_quad timer_quad_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .load_i    (load_i),
  .load_val_i(load_val_i),
  .ev_valid  (ev_valid),
  .ev_up     (ev_up),
  .count_o   (count_o)
);

// File: tb/sim_timer_quad.sv
module sim_timer_quad;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd2;
  logic [2:0]  presc_sel_i = 3'd0;
  logic        tclk_pin_i = 1'b0;
  logic        tdir_pin_i = 1'b0;
  logic        casc_tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic        clr_i = 1'b0;
  logic [15:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk_i = ~clk_i;

  timer_quad u0 (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: count_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_i = 2'd2; casc_tick_i = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] v);
    load_i = 1'b1; load_val_i = v;
    cyc(1);
    load_i = 1'b0;
  endtask

  task automatic pins(input logic a, input logic b);
    tclk_pin_i = a; tdir_pin_i = b;
    cyc(4);
  endtask

  task automatic t_reset();
    check("R1", count_o, 16'h0000);
  endtask

  task automatic t_pin_edges();
    idle(); pins(1'b0, 1'b1);
    do_load(16'd100);
    mode_i = 2'd1;
    pins(1'b1, 1'b1); check("R2 rise", count_o, 16'd101);
    pins(1'b0, 1'b1); check("R2 fall", count_o, 16'd102);
    pins(1'b0, 1'b0); check("R2 dir only", count_o, 16'd102);
    pins(1'b1, 1'b0); check("R3 down", count_o, 16'd101);
    pins(1'b0, 1'b0); check("R3 down", count_o, 16'd100);
  endtask

  task automatic t_quad_fwd_rev();
    idle(); pins(1'b0, 1'b0);
    do_load(16'd500);
    mode_i = 2'd3;
    pins(1'b1, 1'b0); check("R4 fwd 10", count_o, 16'd501);
    pins(1'b1, 1'b1); check("R4 fwd 11", count_o, 16'd502);
    pins(1'b0, 1'b1); check("R4 fwd 01", count_o, 16'd503);
    pins(1'b0, 1'b0); check("R4 fwd 00", count_o, 16'd504);
    pins(1'b0, 1'b1); check("R4 rev 01", count_o, 16'd503);
    pins(1'b1, 1'b1); check("R4 rev 11", count_o, 16'd502);
    pins(1'b1, 1'b0); check("R4 rev 10", count_o, 16'd501);
    pins(1'b0, 1'b0); check("R4 rev 00", count_o, 16'd500);
  endtask

  task automatic t_quad_double();
    mode_i = 2'd3;
    pins(1'b1, 1'b1); check("R5 00->11", count_o, 16'd500);
    pins(1'b0, 1'b1); check("R5 resume", count_o, 16'd501);
    pins(1'b1, 1'b0); check("R5 01->10", count_o, 16'd501);
  endtask

  task automatic t_presc();
    logic [15:0] c0;
    idle(); pins(1'b0, 1'b1);
    do_load(16'd1000);
    presc_sel_i = 3'd3; mode_i = 2'd0;
    cyc(1); c0 = count_o;
    cyc(64); check("R6 div8", count_o - c0, 16'd8);
    idle(); pins(1'b0, 1'b0);
    presc_sel_i = 3'd0; mode_i = 2'd0;
    c0 = count_o;
    cyc(10); check("R6 div1 R3 down", c0 - count_o, 16'd10);
  endtask

  task automatic t_casc();
    idle(); pins(1'b0, 1'b1);
    do_load(16'd7);
    pins(1'b1, 1'b1); pins(1'b0, 1'b1);
    check("R7 pin ignored", count_o, 16'd7);
    casc_tick_i = 1'b1; cyc(3); casc_tick_i = 1'b0; cyc(1);
    check("R7 three ticks", count_o, 16'd10);
  endtask

  task automatic t_wrap();
    idle(); pins(1'b0, 1'b1);
    do_load(16'hFFFF);
    mode_i = 2'd1;
    pins(1'b1, 1'b1); check("R8 up wrap", count_o, 16'h0000);
    pins(1'b1, 1'b0);
    pins(1'b0, 1'b0); check("R8 down wrap", count_o, 16'hFFFF);
  endtask

  task automatic t_load_prio();
    idle(); pins(1'b0, 1'b1);
    load_i = 1'b1; load_val_i = 16'h1234; casc_tick_i = 1'b1;
    cyc(1);
    load_i = 1'b0;
    check("R9 load over step", count_o, 16'h1234);
    cyc(1); casc_tick_i = 1'b0;
    check("R9 step after load", count_o, 16'h1235);
  endtask

  task automatic t_clear_prio();
    idle();
    clr_i = 1'b1; load_i = 1'b1; load_val_i = 16'd55; casc_tick_i = 1'b1;
    cyc(1);
    clr_i = 1'b0; load_i = 1'b0; casc_tick_i = 1'b0;
    check("R10 clear over load", count_o, 16'h0000);
    cyc(2); check("R10 stays", count_o, 16'h0000);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: count_o=%h expected run end", count_o);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_pin_edges();
    t_quad_fwd_rev();
    t_quad_double();
    t_presc();
    t_casc();
    t_wrap();
    t_load_prio();
    t_clear_prio();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule